// File: doc/BRIEF.md
# Punctured Rate-1/2 Convolutional Encoder

This block encodes a stream of information bits with a rate-1/2 convolutional code of constraint length 5. Each accepted bit produces a pair of coded bits. The first bit of the pair comes from the generator 1+D^3+D^4, and the second comes from 1+D+D^3+D^4. A block begins with a start pulse, which clears the four memory stages and latches a rate selection. The encoder then takes data bits through a valid/ready handshake. After the data it inserts four zero tail bits by itself, so the memory ends the block at zero.

The rate selection sets the block length. At half rate a block has 228 steps (224 data bits and 4 tail bits), and every coded bit is sent. At three-quarter rate a block has 338 steps (334 data bits and 4 tail bits), and a fixed pattern removes 220 of the 676 coded bits. The removed positions are indexed by coded-bit position, counted from 0 across the block. Either rate sends 456 coded bits per block.

Input handshake: a bit is taken on a rising edge where `in_valid` and `in_ready` are both high. The source may hold `in_valid` low for any number of cycles, and the encoder waits. The output side has no back-pressure. Each coded pair is shown for exactly one cycle, and the sink must take it then.

Top module: `pconv_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready`, `out_valid` and `blk_done` are all 0.
- R2: For step n, with u the step's input bit and u(k)=0 for k before the block, `out_bits[0]` = u(n)^u(n-3)^u(n-4) and `out_bits[1]` = u(n)^u(n-1)^u(n-3)^u(n-4). From a fresh block, inputs 1,0,0,1 give pairs (bit0,bit1) 11, 01, 00, 00.
- R3: When idle, a `blk_start` pulse opens a block. It clears the memory and latches `rate_sel` (0 = half rate, 1 = three-quarter rate). `in_ready` is high in the next cycle, and later changes of `rate_sel` have no effect until the next block.
- R4: During the data phase `in_ready` stays high. A cycle with `in_valid` low neither advances the block nor produces output.
- R5: After the last data bit the encoder runs four tail steps, one per cycle, with input 0. `in_ready` is low during them and `in_valid`/`in_data` are ignored. The memory is zero when the block ends.
- R6: At half rate a block is 228 steps, and both bits of every pair are valid (456 coded bits).
- R7: At three-quarter rate a block is 338 steps. The pair of step n has `out_valid` = 2'b01 (bit1 removed) when 7 <= n <= 335 and n mod 3 is 1 or 2. This is coded index 2n+1 = 3+6j or 5+6j for j = 2..111. Otherwise `out_valid` = 2'b11, for 456 coded bits in total.
- R8: The pair for a step taken on a clock edge is on `out_bits`/`out_valid` from that edge until the next. `out_valid` is 2'b00 in cycles without a step.
- R9: `blk_done` is a one-cycle pulse in the same cycle as the last pair of the block. After it the encoder is idle with `in_ready` low.
- R10: A `blk_start` while a block is in progress is ignored. The block continues with its memory, position and rate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Opens a block when idle |
| rate_sel | input | 1 | 0 = half rate, 1 = three-quarter rate, latched at start |
| in_valid | input | 1 | Information bit on `in_data` is valid |
| in_data | input | 1 | Information bit |
| in_ready | output | 1 | Encoder accepts a data bit this cycle |
| out_valid | output | 2 | Per-bit valid of the coded pair (bit 0 = first generator) |
| out_bits | output | 2 | Coded pair, bit 0 first generator, bit 1 second |
| blk_done | output | 1 | Pulse with the last coded pair of a block |

## Verification
The bench checks every coded pair against a reference shift register over whole blocks in both rates. It includes the short sequence from the requirements, so swapped or wrong taps show up as bit mismatches. The edges of the removal window (steps 6/7 and 335/336) are exercised. A window off by one step, or a phase counter that restarts wrongly, changes the per-cycle `out_valid` pattern and the 456-bit total. During the tail the bench drives `in_valid` high with data 1. A design that accepted those bits would send wrong tail pairs, and a design that skipped or miscounted the tail would pulse `blk_done` at the wrong step. Idle gaps in the input and a start pulse in the middle of a block would show, respectively, stray output and a reset of the position or memory.

// File: rtl/pconv_pkg.sv
package pconv_pkg;
  typedef enum logic {
    RATE_HALF = 1'b0,
    RATE_3Q   = 1'b1
  } rate_e;

  localparam int MEM_STAGES = 4;
  localparam logic [MEM_STAGES:0] TAPS_FIRST  = 5'b11001; // u, u-3, u-4
  localparam logic [MEM_STAGES:0] TAPS_SECOND = 5'b11011; // u, u-1, u-3, u-4
  localparam int STEPS_HALF = 228;
  localparam int STEPS_3Q   = 338;
  localparam int J_LO = 2;
  localparam int J_HI = 111;
endpackage

// File: rtl/pconv_shift.sv
module pconv_shift #(
  parameter int MEM = 4,
  parameter logic [MEM:0] TAPS0 = 5'b11001,
  parameter logic [MEM:0] TAPS1 = 5'b11011
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  input  logic           u,
  output logic [1:0]     coded,
  output logic [MEM-1:0] state
);
  logic [MEM-1:0] sr;
  logic [MEM:0]   window;

  // window[i] holds u(n-i)
  assign window   = {sr, u};
  assign coded[0] = ^(window & TAPS0);
  assign coded[1] = ^(window & TAPS1);
  assign state    = sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (clr)   sr <= '0;
    else if (step)  sr <= {sr[MEM-2:0], u};
  end
endmodule

// File: rtl/pconv_ctrl.sv
module pconv_ctrl #(
  parameter int LEN_A = 228,
  parameter int LEN_B = 338,
  parameter int TAIL  = 4,
  parameter int IDXW  = $clog2(LEN_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              rate_sel,
  input  logic              in_valid,
  output logic              busy,
  output logic              start_acc,
  output logic              in_ready,
  output logic              step,
  output logic              tail,
  output logic              last,
  output logic              mode,
  output logic [IDXW-1:0]   idx
);
  localparam logic [IDXW-1:0] LEN_A_W = IDXW'(LEN_A);
  localparam logic [IDXW-1:0] LEN_B_W = IDXW'(LEN_B);
  localparam logic [IDXW-1:0] TAIL_W  = IDXW'(TAIL);

  pconv_pkg::rate_e mode_q;
  logic [IDXW-1:0]  len;

  assign mode      = mode_q;
  assign len       = (mode_q == pconv_pkg::RATE_3Q) ? LEN_B_W : LEN_A_W;
  assign start_acc = !busy && blk_start;
  assign tail      = busy && (idx >= len - TAIL_W);
  assign in_ready  = busy && !tail;
  assign step      = busy && (tail || in_valid);
  assign last      = step && (idx == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      mode_q <= pconv_pkg::RATE_HALF;
    end else if (start_acc) begin
      busy   <= 1'b1;
      idx    <= '0;
      mode_q <= pconv_pkg::rate_e'(rate_sel);
    end else if (step) begin
      if (last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx  <= idx + 1'b1;
      end
    end
  end

  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx < len);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blk_start && !last) |=> (busy && mode_q == $past(mode_q) && idx >= $past(idx)));
endmodule

// File: rtl/pconv_punct.sv
module pconv_punct #(
  parameter int IDXW    = 9,
  parameter int N_FIRST = 7,
  parameter int N_LAST  = 335
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic            mode,
  input  logic [IDXW-1:0] idx,
  output logic [1:0]      keep
);
  localparam logic [IDXW-1:0] LO_W = IDXW'(N_FIRST);
  localparam logic [IDXW-1:0] HI_W = IDXW'(N_LAST);

  // step index modulo 3: coded index 2n+1 mod 6 is 3 or 5 when n mod 3 is 1 or 2
  logic [1:0] ph;
  logic       in_window;

  always_ff @(posedge clk) begin
    if (!rst_n)    ph <= 2'd0;
    else if (clr)  ph <= 2'd0;
    else if (step) ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
  end

  assign in_window = (idx >= LO_W) && (idx <= HI_W);
  assign keep[0]   = 1'b1;
  assign keep[1]   = !(mode && in_window && (ph != 2'd0));

  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 2'd3);
endmodule

// File: rtl/pconv_encoder.sv
module pconv_encoder #(
  parameter int MEM   = pconv_pkg::MEM_STAGES,
  parameter logic [MEM:0] TAPS0 = pconv_pkg::TAPS_FIRST,
  parameter logic [MEM:0] TAPS1 = pconv_pkg::TAPS_SECOND,
  parameter int LEN_A = pconv_pkg::STEPS_HALF,
  parameter int LEN_B = pconv_pkg::STEPS_3Q,
  parameter int J_LO  = pconv_pkg::J_LO,
  parameter int J_HI  = pconv_pkg::J_HI
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_start,
  input  logic       rate_sel,
  input  logic       in_valid,
  input  logic       in_data,
  output logic       in_ready,
  output logic [1:0] out_valid,
  output logic [1:0] out_bits,
  output logic       blk_done
);
  localparam int IDXW    = $clog2(LEN_B);
  localparam int N_FIRST = 3 * J_LO + 1;
  localparam int N_LAST  = 3 * J_HI + 2;

  logic            busy, start_acc, step, tail, last, mode;
  logic [IDXW-1:0] idx;
  logic [1:0]      coded, keep;
  logic [MEM-1:0]  sr_state;
  logic            u;

  pconv_ctrl #(.LEN_A(LEN_A), .LEN_B(LEN_B), .TAIL(MEM), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .rate_sel(rate_sel),
    .in_valid(in_valid), .busy(busy), .start_acc(start_acc), .in_ready(in_ready),
    .step(step), .tail(tail), .last(last), .mode(mode), .idx(idx)
  );

  assign u = tail ? 1'b0 : in_data;

  pconv_shift #(.MEM(MEM), .TAPS0(TAPS0), .TAPS1(TAPS1)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .step(step), .u(u),
    .coded(coded), .state(sr_state)
  );

  pconv_punct #(.IDXW(IDXW), .N_FIRST(N_FIRST), .N_LAST(N_LAST)) u_punct (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .step(step), .mode(mode),
    .idx(idx), .keep(keep)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 2'b00;
      out_bits  <= 2'b00;
      blk_done  <= 1'b0;
    end else begin
      out_valid <= step ? keep : 2'b00;
      out_bits  <= coded;
      blk_done  <= last;
    end
  end

  p_flush_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (sr_state == '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  p_first_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != 2'b00) |-> out_valid[0]);

  p_half_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != 2'b00 && mode == 1'b0) |-> out_valid == 2'b11);

  p_tail_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tail |-> !in_ready);
endmodule

// File: tb/sim_pconv_encoder.sv
module sim_pconv_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blk_start = 1'b0;
  logic       rate_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_data = 1'b0;
  logic       in_ready;
  logic [1:0] out_valid;
  logic [1:0] out_bits;
  logic       blk_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pconv_encoder u0 (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_bits(out_bits), .blk_done(blk_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_pair(input logic u, input logic [3:0] s);
    // s[i] = u(n-1-i)
    ref_pair[0] = u ^ s[2] ^ s[3];
    ref_pair[1] = u ^ s[0] ^ s[2] ^ s[3];
  endfunction

  function automatic logic pat_bit(input int pat, input int n);
    case (pat)
      0:       pat_bit = (n == 0 || n == 3);
      1:       pat_bit = logic'((((n * 13) ^ (n >> 2)) >> 1) & 1);
      default: pat_bit = 1'b1;
    endcase
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 0 && out_valid == 0 && blk_done == 0, "R1 reset outputs",
        {in_ready, out_valid, blk_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 0 && out_valid == 0 && blk_done == 0, "R1 after reset",
        {in_ready, out_valid, blk_done}, 0);
  endtask

  task automatic run_block(input logic mode, input int pat, input bit gaps, input bit poke);
    int len = mode ? 338 : 228;
    logic [3:0] msr = 4'b0;
    int nvalid = 0;
    logic [1:0] lit [4] = '{2'b11, 2'b10, 2'b00, 2'b00};
    @(negedge clk);
    blk_start = 1'b1; rate_sel = mode; in_valid = 1'b0;
    @(negedge clk);
    blk_start = 1'b0; rate_sel = ~mode;
    chk(in_ready == 1, "R3 ready after start", int'(in_ready), 1);
    for (int n = 0; n < len; n++) begin
      logic u;
      logic [1:0] eb, ev;
      bit is_tail = (n >= len - 4);
      if (!is_tail && gaps && (n % 7 == 3)) begin
        in_valid = 1'b0; blk_start = 1'b0;
        @(negedge clk);
        chk(out_valid == 0, "R4 gap no output", int'(out_valid), 0);
        chk(in_ready == 1, "R4 gap ready held", int'(in_ready), 1);
      end
      blk_start = (poke && n == 50);
      if (is_tail) begin
        chk(in_ready == 0, "R5 tail ready low", int'(in_ready), 0);
        in_valid = 1'b1; in_data = 1'b1; u = 1'b0;
      end else begin
        u = pat_bit(pat, n);
        in_valid = 1'b1; in_data = u;
      end
      eb  = ref_pair(u, msr);
      msr = {msr[2:0], u};
      ev  = (mode && n >= 7 && n <= 335 && (n % 3 != 0)) ? 2'b01 : 2'b11;
      @(negedge clk);
      if (mode) chk(out_valid == ev, "R7 R8 valid mask", int'(out_valid), int'(ev));
      else      chk(out_valid == ev, "R6 R8 valid mask", int'(out_valid), int'(ev));
      chk(((out_bits ^ eb) & ev) == 0, "R2 coded pair", int'(out_bits), int'(eb));
      if (poke) chk(((out_bits ^ eb) & ev) == 0, "R10 pair after ignored start",
                    int'(out_bits), int'(eb));
      chk(blk_done == (n == len - 1), "R9 done timing", int'(blk_done), int'(n == len - 1));
      if (pat == 0 && n < 4)
        chk(out_bits == lit[n], "R2 worked sequence", int'(out_bits), int'(lit[n]));
      nvalid += $countones(out_valid);
    end
    in_valid = 1'b0; blk_start = 1'b0;
    if (mode) chk(nvalid == 456, "R7 coded total", nvalid, 456);
    else      chk(nvalid == 456, "R6 coded total", nvalid, 456);
    @(negedge clk);
    chk(out_valid == 0 && blk_done == 0 && in_ready == 0, "R9 idle after done",
        {in_ready, out_valid, blk_done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_block(1'b0, 0, 1'b0, 1'b0);  // worked sequence, half rate
    run_block(1'b1, 1, 1'b0, 1'b0);  // three-quarter rate, mixed data
    run_block(1'b0, 1, 1'b1, 1'b1);  // gaps and start mid-block
    run_block(1'b1, 2, 1'b1, 1'b1);  // all ones, gaps, ignored start
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule